// File: doc/BRIEF.md
# Sliding-Window History Buffer

This block keeps the most recent samples of a data stream in a fixed-depth window held in inferred synchronous RAM. Each write appends a sample as the newest entry. Once the window holds its full depth, every further write also retires the oldest entry. Software-free logic downstream reads any stored sample by its age, where index 0 is always the oldest entry still held. No data is ever copied inside the RAM. A circular write pointer is added to the requested age to form the physical address, so each write seems to move every entry one place toward index 0.

Reads are registered and have one cycle of latency. A read in the same cycle as a write sees the window as it stood before that write. A fill count and a full flag report how much of the window is occupied. A read of an age that holds nothing raises an invalid flag next to the returned word.

Top module: `hist_window_buf`

## Requirements
- R1: While `rst` is high at a rising edge, `fill_cnt` becomes 0 and `full` and `rd_invalid` become 0 after that edge.
- R2: Each write raises `fill_cnt` by one until it reaches DEPTH. From then on it stays at DEPTH, and it never exceeds DEPTH.
- R3: `full` is 1 exactly when `fill_cnt` equals DEPTH. Once set, it stays set until reset.
- R4: Before the window is full, a read at index i returns the (i+1)-th sample written since reset.
- R5: When the window is full, a write drops the oldest sample. Afterwards index 0 returns the oldest surviving sample and index DEPTH-1 returns the sample just written.
- R6: `rd_data` and `rd_invalid` change only on the rising edge that follows a cycle with `rd_en` high. In cycles with `rd_en` low they hold their values.
- R7: When a read and a write fall in the same cycle, the read uses the index mapping and the contents from before that write.
- R8: A read whose index is greater than or equal to `fill_cnt` sets `rd_invalid` to 1. A read whose index is below `fill_cnt` sets it to 0 and returns valid data.
- R9: After a reset, index 0 maps to the first sample written after that reset, even if earlier samples were stored in other RAM locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Append `wr_data` as the newest sample |
| wr_data | input | DATA_W | Sample to append |
| rd_en | input | 1 | Start a read of age `rd_idx` |
| rd_idx | input | IDX_W | Age of the sample to read, 0 = oldest |
| rd_data | output | DATA_W | Read result, valid one cycle after `rd_en` |
| rd_invalid | output | 1 | Last read addressed an empty age |
| fill_cnt | output | CNT_W | Number of samples held, 0 to DEPTH |
| full | output | 1 | Window holds DEPTH samples |

## Verification
The bench builds the block with DEPTH = 6 and DATA_W = 12. A depth that is not a power of two makes the modulo wrap of the pointer sum a real subtraction, not a dropped carry. The 3-bit index can also name ages 6 and 7, which lie outside the window even when it is full. The small depth lets a long write stream wrap the pointer many times. This exercises the pointer-plus-age sum at every offset against a queue model of the window.

// File: rtl/hist_window_pkg.sv
package hist_window_pkg;

  // Modular sum of a base position and an offset within a ring of `ring` slots.
  // Both operands are assumed below `ring`.
  function automatic int ring_add(input int base, input int offs, input int ring);
    int s;
    s = base + offs;
    if (s >= ring) s = s - ring;
    return s;
  endfunction

  // Next slot after `pos` in a ring of `ring` slots.
  function automatic int ring_next(input int pos, input int ring);
    return (pos == ring - 1) ? 0 : pos + 1;
  endfunction

  // An age is held when it lies below the current occupancy.
  function automatic bit age_held(input int age, input int occupancy);
    return age < occupancy;
  endfunction

endpackage

// File: rtl/hist_window_occ.sv
module hist_window_occ #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  output logic [IDX_W-1:0] wr_ptr,
  output logic [IDX_W-1:0] oldest_ptr,
  output logic [CNT_W-1:0] fill,
  output logic             full
);
  import hist_window_pkg::*;

  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH);

  logic [IDX_W-1:0] ptr_next;
  logic             reach_full;

  always_comb begin
    ptr_next   = IDX_W'(ring_next(int'(wr_ptr), DEPTH));
    reach_full = wr_en && (fill == FILL_MAX - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      fill   <= '0;
      full   <= 1'b0;
    end else if (wr_en) begin
      wr_ptr <= ptr_next;
      if (!full) fill <= fill + 1'b1;
      if (reach_full) full <= 1'b1;
    end
  end

  // Until the first wrap the oldest sample sits in slot 0; afterwards it is
  // the slot the next write will overwrite.
  assign oldest_ptr = full ? wr_ptr : '0;

endmodule

// File: rtl/hist_window_map.sv
module hist_window_map #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0] oldest_ptr,
  input  logic [IDX_W-1:0] age,
  input  logic [CNT_W-1:0] fill,
  output logic [IDX_W-1:0] phys_addr,
  output logic             age_empty
);
  import hist_window_pkg::*;

  always_comb begin
    age_empty = !age_held(int'(age), int'(fill));
    // An empty age may exceed DEPTH-1; fold it so the address stays in range.
    if (age_empty)
      phys_addr = oldest_ptr;
    else
      phys_addr = IDX_W'(ring_add(int'(oldest_ptr), int'(age), DEPTH));
  end

endmodule

// File: rtl/hist_window_ram.sv
module hist_window_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write: the registered read sees the old word on a collision.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hist_window_buf.sv
module hist_window_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_invalid,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              full
);

  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0] wr_ptr;
  logic [IDX_W-1:0] oldest_ptr;
  logic [IDX_W-1:0] rd_phys;
  logic             rd_age_empty;
  logic             wr_fire;
  logic             rd_fire;

  assign wr_fire = wr_en && !rst;
  assign rd_fire = rd_en && !rst;

  hist_window_occ #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_occ (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_fire),
    .wr_ptr     (wr_ptr),
    .oldest_ptr (oldest_ptr),
    .fill       (fill_cnt),
    .full       (full)
  );

  hist_window_map #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_map (
    .oldest_ptr (oldest_ptr),
    .age        (rd_idx),
    .fill       (fill_cnt),
    .phys_addr  (rd_phys),
    .age_empty  (rd_age_empty)
  );

  hist_window_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (rd_fire),
    .raddr (rd_phys),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          rd_invalid <= 1'b0;
    else if (rd_fire) rd_invalid <= rd_age_empty;
  end

endmodule

// File: rtl/hist_window_chk.sv
module hist_window_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_invalid,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic              full,
  input logic [IDX_W-1:0]  wr_ptr
);

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: state cleared after a reset edge
  always_ff @(posedge clk) begin
    if (rst_seen)
      assert_reset_clear_R1: assert (fill_cnt == '0 && !full && !rd_invalid);
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  assert_fill_step_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full) |=> (fill_cnt == $past(fill_cnt) + 1'b1));

  assert_full_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    full |=> full);

  assert_full_level_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> (fill_cnt == CNT_W'(DEPTH)));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (($past(wr_ptr) == IDX_W'(DEPTH - 1)) ? (wr_ptr == '0)
                                                    : (wr_ptr == $past(wr_ptr) + 1'b1)));

  assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_data) && $stable(rd_invalid)));

  assert_empty_age_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ({1'b0, rd_idx} >= (IDX_W + 1)'(fill_cnt))) |=> rd_invalid);

endmodule

bind hist_window_buf hist_window_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_idx     (rd_idx),
  .rd_data    (rd_data),
  .rd_invalid (rd_invalid),
  .fill_cnt   (fill_cnt),
  .full       (full),
  .wr_ptr     (wr_ptr)
);

// File: tb/hist_window_buf_test.sv
module hist_window_buf_test;

  localparam int DATA_W = 12;
  localparam int DEPTH  = 6;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef struct {
    bit              chk_data;
    bit              chk_inv;
    logic [DATA_W-1:0] data;
    bit              inv;
    int              fill;
    bit              full;
    string           tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_invalid;
  logic [CNT_W-1:0]  fill_cnt;
  logic              full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] last_data = '0;
  bit                last_inv = 1'b0;
  bit                data_known = 1'b0;
  exp_t              exp_q[$];

  always #10 clk = ~clk;

  hist_window_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_invalid(rd_invalid), .fill_cnt(fill_cnt), .full(full)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Driver: drive one cycle at the falling edge and predict its outcome.
  task automatic step(input bit w, input logic [DATA_W-1:0] wd,
                      input bit r, input int idx, input string tag_in);
    exp_t e;
    string tag;
    @(negedge clk);
    rst = 1'b0; wr_en = w; wr_data = wd; rd_en = r; rd_idx = IDX_W'(idx);
    e.chk_data = 1'b0;
    e.chk_inv  = 1'b1;
    tag = tag_in;
    if (r) begin
      // Prediction uses the window as it was before this cycle's write.
      if (idx < model.size()) begin
        last_data = model[idx]; last_inv = 1'b0; data_known = 1'b1;
      end else begin
        last_inv = 1'b1; data_known = 1'b0;
      end
      if (tag == "") tag = last_inv ? "R8" : (w ? "R7" : (model.size() == DEPTH ? "R5" : "R4"));
    end else if (tag == "") tag = "R6";
    e.chk_data = data_known;
    e.data = last_data;
    e.inv  = last_inv;
    if (w) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back(wd);
    end
    e.fill = model.size();
    e.full = (model.size() == DEPTH);
    e.tag  = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    model.delete();
    last_inv = 1'b0; data_known = 1'b0;
    e.chk_data = 1'b0; e.chk_inv = 1'b1; e.data = '0; e.inv = 1'b0;
    e.fill = 0; e.full = 1'b0; e.tag = "R1";
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compare shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(fill_cnt) == e.fill, (e.tag == "R1") ? "R1" : "R2", "fill_cnt",
              int'(fill_cnt), e.fill);
        check(full == e.full, (e.tag == "R1") ? "R1" : "R3", "full", int'(full), int'(e.full));
        if (e.chk_inv)
          check(rd_invalid == e.inv, e.tag, "rd_invalid", int'(rd_invalid), int'(e.inv));
        if (e.chk_data)
          check(rd_data == e.data, e.tag, "rd_data", int'(rd_data), int'(e.data));
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();                                  // R1
    step(1'b0, '0, 1'b1, 0, "R8");               // empty window: age 0 invalid
    for (int i = 0; i < 3; i++) step(1'b1, DATA_W'(12'h100 + i), 1'b0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, i, "");   // R4 ages 0..2, R8 age 3
    step(1'b0, '0, 1'b0, 0, "R6");               // hold
    step(1'b0, '0, 1'b0, 0, "R6");
    for (int i = 3; i < DEPTH; i++) step(1'b1, DATA_W'(12'h100 + i), 1'b0, 0, "R3");
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, i, "");   // R5 / R8 ages 6,7
    for (int i = 0; i < 4; i++) step(1'b1, DATA_W'(12'h200 + i), 1'b0, 0, "R5");
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, i, "R5");
    step(1'b1, 12'h3A0, 1'b1, 0, "R7");          // collision, full window
    step(1'b1, 12'h3A1, 1'b1, DEPTH - 1, "R7");
    step(1'b0, '0, 1'b1, DEPTH - 1, "R5");       // newest
    do_reset();
    step(1'b1, 12'h5C5, 1'b1, 0, "R7");          // read before first write: invalid
    step(1'b0, '0, 1'b1, 0, "R9");
    step(1'b0, '0, 1'b1, 1, "R8");
    for (int i = 0; i < 300; i++) begin
      int    op;
      op = int'($urandom_range(0, 3));
      step(op[0], DATA_W'($urandom), op[1], int'($urandom_range(0, (1 << IDX_W) - 1)), "");
    end
    step(1'b0, '0, 1'b0, 0, "R6");
    repeat (2) @(posedge clk);
    #5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule